// File: doc/BRIEF.md
# Effective Address Resolver with Page-Wrap Rules

This block turns an addressing-mode request from an 8-bit processor core into a 16-bit effective address. It covers eleven cases: immediate, zero page, zero page indexed by X or Y, absolute, absolute indexed by X or Y, pre-indexed indirect, post-indexed indirect, indirect jump and relative branch. The core supplies the mode code, the two operand bytes, both index registers, the program counter and a branch-condition bit. It then pulses `start`.

Modes that need no memory access produce their result one cycle after the request is accepted. The three indirect modes first read two pointer bytes through a byte read port. That port returns data combinationally in the same cycle. These modes finish two cycles after the direct ones. All zero-page arithmetic stays inside page zero. The indirect jump keeps the classic page-boundary behaviour: the second pointer byte is taken from the start of the same page.

Top module: `addr_resolver`

## Requirements
- R1: After reset, `done`, `bad_mode` and `rd_en` are 0 and `ea` is 0x0000.
- R2: The mode codes are 0 immediate, 1 zero page, 2 zero page+X, 3 zero page+Y, 4 absolute, 5 absolute+X, 6 absolute+Y, 7 pre-indexed indirect, 8 post-indexed indirect, 9 indirect jump and 10 relative. Immediate returns `pc`, which is the address of the operand byte.
- R3: Zero page gives {0x00, op_lo}. The zero-page indexed modes give {0x00, (op_lo + index) mod 256}, so the result never leaves page zero.
- R4: Absolute gives {op_hi, op_lo}. The absolute indexed modes add the zero-extended index to that value modulo 65536.
- R5: Pre-indexed indirect forms p = (op_lo + X) mod 256. It reads the low byte at {0x00, p} and then the high byte at {0x00, (p+1) mod 256}. The result is {high, low}.
- R6: Post-indexed indirect reads the low byte at {0x00, op_lo} and then the high byte at {0x00, (op_lo+1) mod 256}. The result is ({high, low} + Y) mod 65536.
- R7: The indirect jump reads the low byte at {op_hi, op_lo} and then the high byte at {op_hi, (op_lo+1) mod 256}. When op_lo is 0xFF, the high byte therefore comes from offset 0x00 of the same page.
- R8: Relative mode with `take_branch`=1 gives (pc + 1 + sign-extended op_lo) mod 65536. With `take_branch`=0 it gives `pc` unchanged.
- R9: Mode codes 11 to 15 raise `bad_mode` together with `done`, return `ea` = 0x0000 and perform no reads.
- R10: `done` is a one-cycle pulse. It rises one cycle after an accepted request for modes 0–6, 10 and unsupported codes, and three cycles after it for modes 7–9. `ea` holds its value between results.
- R11: An indirect mode performs exactly two reads on consecutive cycles, low byte first. `rd_en` is 0 in every other cycle. A `start` that arrives while a fetch is in progress is ignored and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted when idle |
| mode | input | 4 | Addressing-mode code (R2) |
| op_lo | input | 8 | First operand byte (zero-page address, low address byte or branch offset) |
| op_hi | input | 8 | Second operand byte (high address byte) |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| pc | input | 16 | Address of the first operand byte |
| take_branch | input | 1 | Branch condition for relative mode |
| rd_data | input | 8 | Read data, valid in the same cycle as `rd_addr` |
| rd_en | output | 1 | Pointer read in progress |
| rd_addr | output | 16 | Pointer byte address |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address |
| bad_mode | output | 1 | Unsupported mode flag, valid with `done` |

## Verification
A stale pointer base or index in this block shows up at the ports as a wrong `rd_addr` on the very next cycle, before any result appears. A wrong carry between pointer bytes shows up as a high-byte read in the wrong page. Both are caught by comparing each read address, in order, against the expected one. A mis-sequenced fetch state shows up as a `done` that arrives early, arrives late or arrives twice. The scoreboard compares each `done` with the queued request, so a missing or extra result surfaces within the same request.

// File: rtl/ea_pkg.sv
package ea_pkg;
  parameter int DATA_W = 8;
  localparam int ADDR_W = 2 * DATA_W;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_IMM  = 4'd0,
    AM_ZP   = 4'd1,
    AM_ZPX  = 4'd2,
    AM_ZPY  = 4'd3,
    AM_ABS  = 4'd4,
    AM_ABSX = 4'd5,
    AM_ABSY = 4'd6,
    AM_INDX = 4'd7,
    AM_INDY = 4'd8,
    AM_JIND = 4'd9,
    AM_REL  = 4'd10
  } am_e;

  typedef enum logic [1:0] {
    PF_IDLE = 2'd0,
    PF_LO   = 2'd1,
    PF_HI   = 2'd2
  } pf_e;

  // Next byte address, carry suppressed into the page byte
  function automatic logic [ADDR_W-1:0] page_wrap_inc(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] nxt;
    nxt = a[DATA_W-1:0] + DATA_W'(1);
    return {a[ADDR_W-1:DATA_W], nxt};
  endfunction

  // Page-zero indexed address, 8-bit wrap
  function automatic logic [ADDR_W-1:0] zp_index(input logic [DATA_W-1:0] b,
                                                 input logic [DATA_W-1:0] i);
    logic [DATA_W-1:0] s;
    s = b + i;
    return {{DATA_W{1'b0}}, s};
  endfunction

  // Full-width indexed address, wraps modulo the address space
  function automatic logic [ADDR_W-1:0] abs_index(input logic [ADDR_W-1:0] base,
                                                  input logic [DATA_W-1:0] i);
    return base + {{DATA_W{1'b0}}, i};
  endfunction

  // Branch destination relative to the byte after the offset
  function automatic logic [ADDR_W-1:0] branch_dest(input logic [ADDR_W-1:0] pcv,
                                                    input logic [DATA_W-1:0] off,
                                                    input logic             take);
    return take ? (pcv + ADDR_W'(1) + {{DATA_W{off[DATA_W-1]}}, off}) : pcv;
  endfunction
endpackage

// File: rtl/ea_direct.sv
module ea_direct
  import ea_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [DATA_W-1:0] op_lo,
  input  logic [DATA_W-1:0] op_hi,
  input  logic [DATA_W-1:0] idx_x,
  input  logic [DATA_W-1:0] idx_y,
  input  logic [ADDR_W-1:0] pc,
  input  logic              take_branch,
  output logic [ADDR_W-1:0] direct_ea,
  output logic [ADDR_W-1:0] ptr_base,
  output logic              need_ptr,
  output logic              mode_bad
);
  logic [ADDR_W-1:0] abs_word;
  assign abs_word = {op_hi, op_lo};

  always_comb begin
    direct_ea = '0;
    ptr_base  = '0;
    need_ptr  = 1'b0;
    mode_bad  = 1'b0;
    case (mode)
      AM_IMM:  direct_ea = pc;
      AM_ZP:   direct_ea = zp_index(op_lo, '0);
      AM_ZPX:  direct_ea = zp_index(op_lo, idx_x);
      AM_ZPY:  direct_ea = zp_index(op_lo, idx_y);
      AM_ABS:  direct_ea = abs_word;
      AM_ABSX: direct_ea = abs_index(abs_word, idx_x);
      AM_ABSY: direct_ea = abs_index(abs_word, idx_y);
      AM_INDX: begin
        need_ptr = 1'b1;
        ptr_base = zp_index(op_lo, idx_x);
      end
      AM_INDY: begin
        need_ptr = 1'b1;
        ptr_base = zp_index(op_lo, '0);
      end
      AM_JIND: begin
        need_ptr = 1'b1;
        ptr_base = abs_word;
      end
      AM_REL:  direct_ea = branch_dest(pc, op_lo, take_branch);
      default: mode_bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_ptr_fetch.sv
module ea_ptr_fetch
  import ea_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] ptr_base,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic              hi_phase,
  output logic [ADDR_W-1:0] ptr_val
);
  pf_e               st;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= PF_IDLE;
      base_q <= '0;
      lo_q   <= '0;
    end else begin
      case (st)
        PF_IDLE: if (launch) begin
          base_q <= ptr_base;
          st     <= PF_LO;
        end
        PF_LO: begin
          lo_q <= rd_data;
          st   <= PF_HI;
        end
        default: st <= PF_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_en    = (st != PF_IDLE);
    busy     = (st != PF_IDLE);
    hi_phase = (st == PF_HI);
    case (st)
      PF_LO:   rd_addr = base_q;
      PF_HI:   rd_addr = page_wrap_inc(base_q);
      default: rd_addr = '0;
    endcase
    ptr_val = {rd_data, lo_q};
  end
endmodule

// File: rtl/addr_resolver.sv
module addr_resolver
  import ea_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [MODE_W-1:0]   mode,
  input  logic [DATA_W-1:0]   op_lo,
  input  logic [DATA_W-1:0]   op_hi,
  input  logic [DATA_W-1:0]   idx_x,
  input  logic [DATA_W-1:0]   idx_y,
  input  logic [ADDR_W-1:0]   pc,
  input  logic                take_branch,
  input  logic [DATA_W-1:0]   rd_data,
  output logic                rd_en,
  output logic [ADDR_W-1:0]   rd_addr,
  output logic                done,
  output logic [ADDR_W-1:0]   ea,
  output logic                bad_mode
);
  logic [ADDR_W-1:0] direct_ea;
  logic [ADDR_W-1:0] ptr_base;
  logic [ADDR_W-1:0] ptr_val;
  logic              need_ptr;
  logic              mode_bad;
  logic              fetch_busy;
  logic              ptr_hi_phase;
  logic              req_accept;
  logic              ptr_launch;

  logic              post_y_q;
  logic              jump_q;
  logic [DATA_W-1:0] y_q;
  logic [ADDR_W-1:0] ea_q;
  logic              done_q;
  logic              bad_q;

  ea_direct u_direct (
    .mode        (mode),
    .op_lo       (op_lo),
    .op_hi       (op_hi),
    .idx_x       (idx_x),
    .idx_y       (idx_y),
    .pc          (pc),
    .take_branch (take_branch),
    .direct_ea   (direct_ea),
    .ptr_base    (ptr_base),
    .need_ptr    (need_ptr),
    .mode_bad    (mode_bad)
  );

  assign req_accept = start && !fetch_busy;
  assign ptr_launch = req_accept && need_ptr;

  ea_ptr_fetch u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (ptr_launch),
    .ptr_base (ptr_base),
    .rd_data  (rd_data),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .busy     (fetch_busy),
    .hi_phase (ptr_hi_phase),
    .ptr_val  (ptr_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_q     <= '0;
      done_q   <= 1'b0;
      bad_q    <= 1'b0;
      post_y_q <= 1'b0;
      jump_q   <= 1'b0;
      y_q      <= '0;
    end else begin
      done_q <= 1'b0;
      bad_q  <= 1'b0;
      if (req_accept) begin
        post_y_q <= (mode == AM_INDY);
        jump_q   <= (mode == AM_JIND);
        y_q      <= idx_y;
        if (!need_ptr) begin
          ea_q   <= mode_bad ? '0 : direct_ea;
          bad_q  <= mode_bad;
          done_q <= 1'b1;
        end
      end
      if (ptr_hi_phase) begin
        ea_q   <= post_y_q ? abs_index(ptr_val, y_q) : ptr_val;
        done_q <= 1'b1;
      end
    end
  end

  assign ea       = ea_q;
  assign done     = done_q;
  assign bad_mode = bad_q;
endmodule

// File: rtl/addr_resolver_chk.sv
module addr_resolver_chk
  import ea_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              bad_mode,
  input logic [ADDR_W-1:0] ea,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              req_accept,
  input logic              ptr_hi_phase,
  input logic              fetch_jump
);
  assert_done_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(req_accept) || $past(ptr_hi_phase)));

  assert_bad_zero_ea_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mode |-> (done && ea == '0));

  assert_hi_same_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_hi_phase |-> (rd_en &&
                      rd_addr[ADDR_W-1:DATA_W] == $past(rd_addr[ADDR_W-1:DATA_W]) &&
                      rd_addr[DATA_W-1:0] == DATA_W'($past(rd_addr[DATA_W-1:0]) + 1'b1)));

  assert_two_reads_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_hi_phase |=> !rd_en);

  assert_rd_page_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !fetch_jump) |-> (rd_addr[ADDR_W-1:DATA_W] == '0));
endmodule

bind addr_resolver addr_resolver_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .done         (done),
  .bad_mode     (bad_mode),
  .ea           (ea),
  .rd_en        (rd_en),
  .rd_addr      (rd_addr),
  .req_accept   (req_accept),
  .ptr_hi_phase (ptr_hi_phase),
  .fetch_jump   (jump_q)
);

// File: tb/addr_resolver_tb_top.sv
module addr_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  op_lo = '0, op_hi = '0, idx_x = '0, idx_y = '0;
  logic [15:0] pc = '0;
  logic        take_branch = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_en, done, bad_mode;
  logic [15:0] rd_addr, ea;

  always #2 clk = ~clk;

  function automatic int mem_i(input int a);
    return (((a & 255) ^ 'h5A) + 3 * ((a >> 8) & 255)) & 255;
  endfunction

  assign rd_data = 8'(mem_i(int'(rd_addr)));

  addr_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .op_lo(op_lo),
    .op_hi(op_hi), .idx_x(idx_x), .idx_y(idx_y), .pc(pc),
    .take_branch(take_branch), .rd_data(rd_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .done(done), .ea(ea), .bad_mode(bad_mode)
  );

  typedef struct {
    int    e;
    int    bad;
    int    nrd;
    int    r0;
    int    r1;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0, n_bad = 0, n_issued = 0, n_done = 0;
  int   rd_cnt = 0;
  int   rd_seen[2];
  bit   ended = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic exp_t model(input int m, input int lo, input int hi,
                                 input int x, input int y, input int pcv,
                                 input int tk, input string tag);
    exp_t r;
    int p, off;
    r.e = 0; r.bad = 0; r.nrd = 0; r.r0 = 0; r.r1 = 0; r.tag = tag;
    case (m)
      0: r.e = pcv;
      1: r.e = lo;
      2: r.e = (lo + x) % 256;
      3: r.e = (lo + y) % 256;
      4: r.e = hi * 256 + lo;
      5: r.e = (hi * 256 + lo + x) % 65536;
      6: r.e = (hi * 256 + lo + y) % 65536;
      7: begin
        p = (lo + x) % 256;
        r.nrd = 2; r.r0 = p; r.r1 = (p + 1) % 256;
        r.e = mem_i(r.r1) * 256 + mem_i(r.r0);
      end
      8: begin
        r.nrd = 2; r.r0 = lo; r.r1 = (lo + 1) % 256;
        r.e = (mem_i(r.r1) * 256 + mem_i(r.r0) + y) % 65536;
      end
      9: begin
        r.nrd = 2; r.r0 = hi * 256 + lo; r.r1 = hi * 256 + (lo + 1) % 256;
        r.e = mem_i(r.r1) * 256 + mem_i(r.r0);
      end
      10: begin
        off = (lo >= 128) ? lo - 256 : lo;
        r.e = tk ? (pcv + 1 + off + 65536) % 65536 : pcv;
      end
      default: r.bad = 1;
    endcase
    return r;
  endfunction

  task automatic drive(input int m, input int lo, input int hi, input int x,
                       input int y, input int pcv, input int tk);
    mode = 4'(m); op_lo = 8'(lo); op_hi = 8'(hi);
    idx_x = 8'(x); idx_y = 8'(y); pc = 16'(pcv); take_branch = tk[0];
  endtask

  task automatic issue(input int m, input int lo, input int hi, input int x,
                       input int y, input int pcv, input int tk, input string tag);
    q.push_back(model(m, lo, hi, x, y, pcv, tk, tag));
    n_issued++;
    @(negedge clk);
    drive(m, lo, hi, x, y, pcv, tk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_en) begin
        if (rd_cnt < 2) rd_seen[rd_cnt] = int'(rd_addr);
        rd_cnt++;
      end
      if (done) begin
        n_done++;
        if (q.size() == 0) begin
          check(1'b0, "R11", "unexpected done", 1, 0);
        end else begin
          exp_t x;
          x = q.pop_front();
          check(int'(bad_mode) == x.bad, x.tag, "bad_mode", int'(bad_mode), x.bad);
          check(int'(ea) == x.e, x.tag, "ea", int'(ea), x.e);
          check(rd_cnt == x.nrd, x.tag, "read count", rd_cnt, x.nrd);
          if (x.nrd == 2 && rd_cnt == 2) begin
            check(rd_seen[0] == x.r0, x.tag, "first read addr", rd_seen[0], x.r0);
            check(rd_seen[1] == x.r1, x.tag, "second read addr", rd_seen[1], x.r1);
          end
        end
        rd_cnt = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R10 watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1", "done", int'(done), 0);
    check(bad_mode == 1'b0, "R1", "bad_mode", int'(bad_mode), 0);
    check(rd_en == 1'b0, "R1", "rd_en", int'(rd_en), 0);
    check(ea == 16'h0, "R1", "ea", int'(ea), 0);

    issue(0, 'h33, 'h44, 0, 0, 'h1234, 0, "R2");
    issue(1, 'h80, 'h12, 0, 0, 'h0400, 0, "R3");
    issue(2, 'hF0, 'h12, 'h20, 0, 0, 0, "R3");
    issue(3, 'h10, 'h99, 0, 'h05, 0, 0, "R3");
    issue(4, 'h23, 'hC1, 0, 0, 0, 0, "R4");
    issue(5, 'hF0, 'hFF, 'h20, 0, 0, 0, "R4");
    issue(6, 'hF0, 'h12, 0, 'h30, 0, 0, "R4");
    issue(7, 'hFE, 'h00, 'h01, 0, 0, 0, "R5");
    issue(7, 'h10, 'h00, 'h05, 0, 0, 0, "R5");
    issue(8, 'hFF, 'h00, 0, 'h10, 0, 0, "R6");
    issue(8, 'h40, 'h00, 0, 'hFF, 0, 0, "R6");
    issue(9, 'hFF, 'h30, 0, 0, 0, 0, "R7");
    issue(9, 'h40, 'h20, 0, 0, 0, 0, "R7");
    issue(10, 'h10, 0, 0, 0, 'h8000, 1, "R8");
    issue(10, 'h80, 0, 0, 0, 'h8000, 1, "R8");
    issue(10, 'hFE, 0, 0, 0, 'hFFFF, 1, "R8");
    issue(10, 'h10, 0, 0, 0, 'h8000, 0, "R8");
    issue(13, 'h10, 'h20, 0, 0, 'h1234, 1, "R9");
    // R10: ea holds after the done pulse
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R10", "done after pulse", int'(done), 0);
    check(ea == 16'h0, "R10", "ea held", int'(ea), 0);

    // R11: start held while an indirect fetch runs; later requests ignored
    q.push_back(model(7, 'h20, 0, 'h03, 0, 0, 0, "R11"));
    n_issued++;
    @(negedge clk);
    drive(7, 'h20, 0, 'h03, 0, 0, 0);
    start = 1'b1;
    @(negedge clk);
    drive(1, 'h77, 0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R11", "pending results", q.size(), 0);
    check(n_done == n_issued, "R11", "done count", n_done, n_issued);
    check(rd_en == 1'b0, "R11", "rd_en idle", int'(rd_en), 0);
    finish_run();
  end
endmodule